// File: doc/BRIEF.md
# Three-Axis Acceleration Sample FIFO

This block collects acceleration samples, one 48-bit entry per output-data tick made of the X, Y and Z words. A host drains the entries later in bursts instead of servicing every tick. A run-time mode picks what happens when the 32-entry store is full:

- **Pass-through:** no storage; only the latest sample is shown.
- **Halt:** new samples are dropped once the store is full.
- **Ring:** the oldest entry gives way to the new one.
- **Armed:** behaves as ring until a trigger pulse, then freezes like halt.

The host pops one entry per strobe from a registered output. It also sees four status values: a fill count, an empty flag, an overrun flag and a watermark flag.

Mode and enable are plain level inputs and can change on any cycle. Passing through the pass-through state is the only way to flush the store. Moving directly between the three storing modes keeps the stored entries.

Top module: `accel_fifo`

## Requirements
- R1: After synchronous reset the fill count is 0, the empty flag is 1, the overrun and watermark flags are 0, and the three output words are 0.
- R2: When `fifo_en` is 0 or `mode` is 0 (pass-through), nothing is stored: the count stays 0 and empty stays 1. A sample valid in one cycle appears on the output words from the next cycle on.
- R3: With `mode` = 1 (halt), a sample arriving while 32 entries are held and no pop is requested is discarded. The overrun flag is then set and the contents are unchanged.
- R4: With `mode` = 2 (ring), a sample arriving while 32 entries are held and no pop is requested evicts the oldest entry. The new sample is stored and the overrun flag is set.
- R5: With `mode` = 3 (armed), the store behaves as in R4 until `trig` is seen high at a clock edge. From the next edge on it behaves as in R3. The trigger memory is lost whenever `mode` is not 3 or the block is in pass-through.
- R6: `fill_count` equals the number of stored entries, saturated at 31. `empty_flag` is 1 exactly when no entry is held.
- R7: A pop on a non-empty store places the oldest entry on the output words in the next cycle, so entries leave in arrival order. The output words hold the layout X, Y, Z.
- R8: A pop on an empty store leaves the output words and the count unchanged.
- R9: The overrun flag stays set until the next pop strobe outside pass-through, which clears it.
- R10: `wm_flag` is 1 exactly when `wm_en` is 1 and the fill count is at least `wm_level`.
- R11: Entering pass-through empties the store and clears overrun. Changing directly between modes 1, 2 and 3 keeps the stored entries.
- R12: A sample and a pop in the same cycle on a full store are both performed in every storing mode, with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New sample strobe |
| in_x | input | 16 | X-axis sample |
| in_y | input | 16 | Y-axis sample |
| in_z | input | 16 | Z-axis sample |
| pop | input | 1 | Host pop strobe |
| fifo_en | input | 1 | Storage enable; 0 forces pass-through |
| mode | input | 2 | 0 pass-through, 1 halt, 2 ring, 3 armed |
| wm_en | input | 1 | Watermark enable |
| wm_level | input | 5 | Watermark level |
| trig | input | 1 | Trigger for armed mode |
| out_x | output | 16 | X word of the popped or latest sample |
| out_y | output | 16 | Y word of the popped or latest sample |
| out_z | output | 16 | Z word of the popped or latest sample |
| wm_flag | output | 1 | Watermark reached |
| ovr_flag | output | 1 | Sample dropped or overwritten since last pop |
| empty_flag | output | 1 | No entry stored |
| fill_count | output | 5 | Stored entries, saturating at 31 |

## Verification
The bench tries several input patterns:

- **Fill past full, one mode at a time.** This separates discarding (halt), eviction (ring) and the trigger switch (armed) by their effect on the output words once the store is drained.
- **Drain below zero.** This exposes the empty-pop hold and the FIFO ordering.
- **Simultaneous push and pop at 32 entries.** This tells an accepted sample apart from a wrongly dropped one.
- **Long pseudo-random run.** Modes, enable, trigger, watermark level and strobes change on their own schedule, so that mode switches both through and around pass-through meet every occupancy.

// File: rtl/accel_fifo_pkg.sv
package accel_fifo_pkg;

    localparam int unsigned AXIS_W  = 16;
    localparam int unsigned ENTRY_W = 3 * AXIS_W;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_HALT  = 2'd1,
        MODE_RING  = 2'd2,
        MODE_ARMED = 2'd3
    } fifo_mode_e;

    typedef struct packed {
        logic [AXIS_W-1:0] x;
        logic [AXIS_W-1:0] y;
        logic [AXIS_W-1:0] z;
    } sample_t;

    // Occupancy shown to the host, clipped to the largest count value.
    function automatic int unsigned clip_count(input int unsigned occ,
                                               input int unsigned limit);
        return (occ > limit) ? limit : occ;
    endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store
    import accel_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_addr,
    input  sample_t       wr_data,
    input  logic [PW-1:0] rd_addr,
    output sample_t       rd_data
);

    sample_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
    import accel_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned OW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          fifo_en,
    input  fifo_mode_e    mode,
    input  logic          trig,
    output logic          wr_en,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [OW-1:0] occ,
    output logic          ovr,
    output logic          do_pop,
    output logic          bypass
);

    logic [PW-1:0] wp_q, rp_q;
    logic [OW-1:0] occ_q;
    logic          ovr_q, armed_q;
    logic          full, empty, freeze, accept, evict, drop;

    // Pointer advance: plain increment for a power-of-two depth, wrap compare otherwise.
    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if ((DEPTH & (DEPTH - 1)) == 0) begin
            return p + PW'(1);
        end else begin
            return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
        end
    endfunction

    always_comb begin
        bypass = !fifo_en || (mode == MODE_OFF);
        full   = (occ_q == OW'(DEPTH));
        empty  = (occ_q == '0);
        freeze = (mode == MODE_HALT) || ((mode == MODE_ARMED) && armed_q);
        do_pop = pop && !empty && !bypass;
        accept = push && !bypass && (!full || do_pop);
        evict  = push && !bypass && full && !do_pop && !freeze;
        drop   = push && !bypass && full && !do_pop && freeze;
        wr_en  = accept || evict;
    end

    always_ff @(posedge clk) begin
        if (rst || bypass) begin
            wp_q    <= '0;
            rp_q    <= '0;
            occ_q   <= '0;
            ovr_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            if (wr_en) begin
                wp_q <= bump(wp_q);
            end
            if (do_pop || evict) begin
                rp_q <= bump(rp_q);
            end
            occ_q <= occ_q + OW'(accept) - OW'(do_pop);
            if (drop || evict) begin
                ovr_q <= 1'b1;
            end else if (pop) begin
                ovr_q <= 1'b0;
            end
            armed_q <= (mode == MODE_ARMED) && (armed_q || trig);
        end
    end

    assign wr_ptr = wp_q;
    assign rd_ptr = rp_q;
    assign occ    = occ_q;
    assign ovr    = ovr_q;

endmodule

// File: rtl/afifo_status.sv
module afifo_status
    import accel_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned OW   = PW + 1
) (
    input  logic [OW-1:0] occ,
    input  logic          wm_en,
    input  logic [PW-1:0] wm_level,
    output logic [PW-1:0] fill_count,
    output logic          empty_flag,
    output logic          wm_flag
);

    localparam int unsigned CMAX = (1 << PW) - 1;

    always_comb begin
        fill_count = PW'(clip_count(int'(occ), CMAX));
        empty_flag = (occ == '0);
        wm_flag    = wm_en && (fill_count >= wm_level);
    end

endmodule

// File: rtl/accel_fifo.sv
module accel_fifo
    import accel_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned OW   = PW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [AXIS_W-1:0] in_x,
    input  logic [AXIS_W-1:0] in_y,
    input  logic [AXIS_W-1:0] in_z,
    input  logic              pop,
    input  logic              fifo_en,
    input  logic [1:0]        mode,
    input  logic              wm_en,
    input  logic [PW-1:0]     wm_level,
    input  logic              trig,
    output logic [AXIS_W-1:0] out_x,
    output logic [AXIS_W-1:0] out_y,
    output logic [AXIS_W-1:0] out_z,
    output logic              wm_flag,
    output logic              ovr_flag,
    output logic              empty_flag,
    output logic [PW-1:0]     fill_count
);

    sample_t       in_s, head_s, out_q;
    logic          wr_en, do_pop, bypass;
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [OW-1:0] occ;

    assign in_s = '{x: in_x, y: in_y, z: in_z};

    afifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .push    (in_valid),
        .pop     (pop),
        .fifo_en (fifo_en),
        .mode    (fifo_mode_e'(mode)),
        .trig    (trig),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .occ     (occ),
        .ovr     (ovr_flag),
        .do_pop  (do_pop),
        .bypass  (bypass)
    );

    afifo_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_ptr),
        .wr_data (in_s),
        .rd_addr (rd_ptr),
        .rd_data (head_s)
    );

    afifo_status #(.DEPTH(DEPTH)) u_status (
        .occ        (occ),
        .wm_en      (wm_en),
        .wm_level   (wm_level),
        .fill_count (fill_count),
        .empty_flag (empty_flag),
        .wm_flag    (wm_flag)
    );

    // Host-facing register: latest sample in pass-through, popped head otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (bypass && in_valid) begin
            out_q <= in_s;
        end else if (do_pop) begin
            out_q <= head_s;
        end
    end

    assign out_x = out_q.x;
    assign out_y = out_q.y;
    assign out_z = out_q.z;

endmodule

// File: rtl/afifo_chk.sv
module afifo_chk #(
    parameter int unsigned PW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          pop,
    input logic          fifo_en,
    input logic [1:0]    mode,
    input logic          wm_en,
    input logic [15:0]   out_x,
    input logic [15:0]   out_y,
    input logic [15:0]   out_z,
    input logic          wm_flag,
    input logic          ovr_flag,
    input logic          empty_flag,
    input logic [PW-1:0] fill_count
);

    localparam logic [PW-1:0] CMAX = '1;

    // R1
    reset_state_chk: assert property (@(posedge clk) rst |=> (empty_flag && !ovr_flag && fill_count == '0));

    // R2
    bypass_empty_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (empty_flag && fill_count == '0 && !ovr_flag));

    // R3
    halt_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && mode == 2'd1 && in_valid && !pop && ovr_flag && fill_count == CMAX)
        |=> ($stable(fill_count) && ovr_flag));

    // R7
    pop_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && mode != 2'd0 && pop && !empty_flag && !in_valid && fill_count != CMAX)
        |=> (fill_count == $past(fill_count) - PW'(1)));

    // R8
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && mode != 2'd0 && pop && empty_flag)
        |=> ($stable(out_x) && $stable(out_y) && $stable(out_z)));

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && mode != 2'd0 && pop) |=> !ovr_flag);

    // R10
    wm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !wm_en |-> !wm_flag);

endmodule

bind accel_fifo afifo_chk #(.PW(PW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .pop        (pop),
    .fifo_en    (fifo_en),
    .mode       (mode),
    .wm_en      (wm_en),
    .out_x      (out_x),
    .out_y      (out_y),
    .out_z      (out_z),
    .wm_flag    (wm_flag),
    .ovr_flag   (ovr_flag),
    .empty_flag (empty_flag),
    .fill_count (fill_count)
);

// File: tb/test_accel_fifo.sv
module test_accel_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_x = '0, in_y = '0, in_z = '0;
    logic        pop = 1'b0;
    logic        fifo_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wm_en = 1'b0;
    logic [4:0]  wm_level = '0;
    logic        trig = 1'b0;
    logic [15:0] out_x, out_y, out_z;
    logic        wm_flag, ovr_flag, empty_flag;
    logic [4:0]  fill_count;

    always #4 clk = ~clk;

    accel_fifo i_accel_fifo (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_z(in_z),
        .pop(pop), .fifo_en(fifo_en), .mode(mode), .wm_en(wm_en), .wm_level(wm_level),
        .trig(trig), .out_x(out_x), .out_y(out_y), .out_z(out_z), .wm_flag(wm_flag),
        .ovr_flag(ovr_flag), .empty_flag(empty_flag), .fill_count(fill_count)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";
    int    seq = 0;

    // Reference state
    logic [47:0] mq[$];
    logic [47:0] m_rd = '0;
    bit          m_ovr = 0;
    bit          m_armed = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s (phase %s) %s: actual %0h expected %0h", req, cur_req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        bit byp, halt;
        if (rst) begin
            mq.delete(); m_rd = '0; m_ovr = 0; m_armed = 0;
            return;
        end
        byp = !fifo_en || mode == 2'd0;
        if (byp) begin
            mq.delete(); m_ovr = 0; m_armed = 0;
            if (in_valid) m_rd = {in_x, in_y, in_z};
            return;
        end
        halt = (mode == 2'd1) || (mode == 2'd3 && m_armed);
        if (pop) m_ovr = 0;
        if (pop && mq.size() > 0) m_rd = mq.pop_front();
        if (in_valid) begin
            if (mq.size() < 32) mq.push_back({in_x, in_y, in_z});
            else if (halt) m_ovr = 1;
            else begin
                void'(mq.pop_front());
                mq.push_back({in_x, in_y, in_z});
                m_ovr = 1;
            end
        end
        m_armed = (mode == 2'd3) && (m_armed || trig);
    endtask

    task automatic compare();
        int sz = mq.size();
        int ec = (sz > 31) ? 31 : sz;
        bit ewm = wm_en && (ec >= int'(wm_level));
        chk(fill_count == 5'(ec), "R6", "fill_count", fill_count, ec);
        chk(empty_flag == (sz == 0), "R6", "empty_flag", empty_flag, sz == 0);
        chk(ovr_flag == m_ovr, "R9", "ovr_flag", ovr_flag, m_ovr);
        chk(wm_flag == ewm, "R10", "wm_flag", wm_flag, ewm);
        chk({out_x, out_y, out_z} == m_rd, "R7", "out_xyz", {out_x, out_y, out_z}, m_rd);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic cyc(input bit v, input bit p, input bit t);
        in_valid = v; pop = p; trig = t;
        if (v) begin
            seq++;
            in_x = 16'(seq); in_y = 16'(seq) ^ 16'hA5A5; in_z = ~16'(seq);
        end
        step();
        in_valid = 0; pop = 0; trig = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        @(negedge clk);
        step(); step();
        rst = 0;
        cur_req = "R1";
        step();
        chk(out_x == 0 && out_y == 0 && out_z == 0, "R1", "reset data", out_x, 0);
        chk(empty_flag && fill_count == 0, "R1", "reset empty", fill_count, 0);

        // Pass-through, both by mode and by enable
        cur_req = "R2";
        fifo_en = 1; mode = 2'd0;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        chk(out_x == 16'(seq), "R2", "newest x", out_x, seq);
        fifo_en = 0; mode = 2'd2;
        for (int i = 0; i < 3; i++) cyc(1, 1, 0);

        // Halt mode fill beyond capacity
        cur_req = "R3";
        fifo_en = 1; mode = 2'd1; wm_en = 1; wm_level = 5'd10;
        for (int i = 0; i < 36; i++) cyc(1, 0, 0);
        chk(ovr_flag == 1, "R3", "overrun after drop", ovr_flag, 1);
        cur_req = "R12";
        cyc(1, 1, 0);
        cur_req = "R9";
        cyc(0, 1, 0);
        cyc(0, 1, 0);

        // Switch to ring mode: contents kept, then overwrite
        cur_req = "R11";
        mode = 2'd2;
        cyc(0, 0, 0);
        cur_req = "R4";
        for (int i = 0; i < 8; i++) cyc(1, 0, 0);
        cur_req = "R12";
        cyc(1, 1, 0);
        cur_req = "R7";
        for (int i = 0; i < 34; i++) cyc(0, 1, 0);
        cur_req = "R8";
        cyc(0, 1, 0);
        cyc(1, 0, 0);
        cyc(0, 1, 0);
        cyc(0, 1, 0);

        // Flush through pass-through, then armed mode
        cur_req = "R11";
        for (int i = 0; i < 10; i++) cyc(1, 0, 0);
        mode = 2'd0;
        cyc(0, 0, 0);
        chk(fill_count == 0, "R11", "flushed count", fill_count, 0);
        cur_req = "R5";
        mode = 2'd3; wm_level = 5'd31;
        for (int i = 0; i < 40; i++) cyc(1, 0, 0);
        cyc(0, 0, 1);
        for (int i = 0; i < 5; i++) cyc(1, 0, 0);
        cyc(0, 1, 0);
        cyc(1, 0, 0);
        cyc(1, 0, 0);
        mode = 2'd2; cyc(0, 0, 0);
        mode = 2'd3;
        for (int i = 0; i < 4; i++) cyc(1, 0, 0);
        for (int i = 0; i < 33; i++) cyc(0, 1, 0);

        // Pseudo-random run
        cur_req = "R11";
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (i % 97 == 0) mode = lfsr[1:0];
            if (i % 211 == 0) fifo_en = (lfsr[4:2] != 3'd0);
            if (i % 53 == 0) begin wm_en = lfsr[5]; wm_level = lfsr[10:6]; end
            cyc(lfsr[0] | lfsr[7], lfsr[3] & lfsr[8], lfsr[15:11] == 5'd0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule